// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block turns bytes into asynchronous serial characters and back again. A divider built into the block derives an oversampling tick from the system clock. Each bit lasts a fixed number of ticks, sixteen by default. A 5-bit mode word selects the character format:
- 7 or 8 data bits;
- one or two stop bits;
- no parity, even parity or odd parity.

On the transmit side, bytes enter through a valid/ready handshake into a single holding stage, so the next character is ready as soon as the current one ends. A break control pulls the line low for as long as it is asserted.

On the receive side, a start bit must be confirmed at mid-bit, and the data is sampled at bit centres, LSB first. Each character is delivered as one 13-bit word: the data byte plus its own parity-error, overrun, framing-error, break and word-valid flags. The word stays on the output until the downstream logic takes it. A character that completes while the previous word is still waiting is dropped, and the next delivered word is marked as overrun.

Top module: `uart_frame_engine`

## Requirements
- R1: One bit lasts OVS × (divisor + 1) clock cycles. Ticks come every divisor + 1 cycles. A transmitted start bit, measured from the start of a frame, spans between (OVS−1)×(divisor+1)+1 and OVS×(divisor+1) cycles.
- R2: Mode bit 0 selects the character length: 1 gives 7 data bits, 0 gives 8. In 7-bit mode the transmitter sends data bits 6:0 and then the stop bit, and received words carry 0 in data bit 7.
- R3: Mode bit 2 selects the stop length: 0 gives one stop bit (high), 1 gives two. With back-to-back characters, the next start bit follows directly after the last stop bit.
- R4: Mode bit 4 enables a parity bit placed after the data. Mode bit 3 selects its sense: 0 gives even parity, 1 gives odd parity.
- R5: The received word carries data in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10, break in bit 11 and valid in bit 12. Data is taken LSB first at bit centres. A valid word holds unchanged until `rx_ready` is high at a clock edge.
- R6: While `break_ctl` is high, `txd` is low from the next clock onward.
- R7: A low pulse that is high again by the eighth tick after its falling edge produces no word.
- R8: A character whose first stop bit samples low is delivered with bit 10 set.
- R9: A character whose data, parity and stop positions all sample low is delivered with bits 11 and 10 set and data 0. The receiver then waits for a high line before it looks for the next start bit.
- R10: A character that completes while a valid word is still waiting is dropped. The next word that is delivered has bit 9 set.
- R11: The idle line is high. `tx_ready` is high only while the holding stage is empty. `tx_empty` is high only when both the holding stage and the shift register are empty.
- R12: With parity enabled, a received parity bit of the wrong sense sets bit 8. With the correct sense, bit 8 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | DIV_W | Tick divider; ticks come every divisor+1 clocks |
| mode | input | 5 | Frame format: bit0 7-bit, bit2 two stops, bit3 odd, bit4 parity on |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding stage can take a byte |
| break_ctl | input | 1 | Force the serial output low |
| txd | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Holding stage and shift register both empty |
| rxd | input | 1 | Serial input |
| rx_word | output | 13 | Received data with status flags, bit 12 valid |
| rx_ready | input | 1 | Downstream takes the received word |

## Verification
The bench builds the block with OVS=16, DIV_W=16 and SYNC_STAGES=2, and drives the divisor port with 3, so a bit lasts 64 clocks. That short bit time makes it practical to run about twenty full frames across all modes, hold a break for many bit times and stage an overrun. It also lets the bench place line samples at exact bit centres. Because the synchronizer is present, the bit-banged glitch and error frames pass through the same two-stage input path a real line would use.

// File: rtl/uafe_pkg.sv
package uafe_pkg;

   localparam int DATA_W    = 8;
   localparam int WORD_W    = 13;
   localparam int FRAME_MAX = 12;
   localparam int NBITS_W   = 4;

   localparam int POS_PE  = 8;
   localparam int POS_OVR = 9;
   localparam int POS_FE  = 10;
   localparam int POS_BRK = 11;
   localparam int POS_VLD = 12;

   typedef struct packed {
      logic par_en;
      logic par_odd;
      logic two_stop;
      logic len7;
   } fmt_t;

   function automatic fmt_t fmt_decode(input logic [4:0] m);
      fmt_t f;
      f.len7     = m[0];
      f.two_stop = m[2];
      f.par_odd  = m[3];
      f.par_en   = m[4];
      return f;
   endfunction

   function automatic logic [NBITS_W-1:0] data_len(input fmt_t f);
      return f.len7 ? NBITS_W'(7) : NBITS_W'(8);
   endfunction

   function automatic logic [DATA_W-1:0] data_mask(input fmt_t f);
      return f.len7 ? 8'h7f : 8'hff;
   endfunction

endpackage

// File: rtl/uafe_tick_gen.sv
module uafe_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (cnt_q >= divisor) begin
         cnt_q  <= '0;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_q <= 1'b0;
      end
   end

   assign tick = tick_q;

endmodule

// File: rtl/uafe_tx.sv
module uafe_tx
   import uafe_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  fmt_t              fmt,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              break_ctl,
   output logic              txd,
   output logic              tx_empty
);

   localparam int OVS_W = $clog2(OVS);
   localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

   logic                 hold_v;
   logic [DATA_W-1:0]    hold_d;
   logic                 busy;
   logic [FRAME_MAX-1:0] frame_q;
   logic [NBITS_W-1:0]   bits_left;
   logic [OVS_W-1:0]     ovs_q;
   logic                 txd_q;

   logic [FRAME_MAX-1:0] ld_frame;
   logic [NBITS_W-1:0]   ld_nbits;

   // Frame image for the held byte, LSB sent first, filled with idle ones.
   always_comb begin
      int unsigned pos;
      logic        pbit;
      ld_frame    = '1;
      ld_frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(data_len(fmt))) ld_frame[1+i] = hold_d[i];
      end
      pos  = 1 + int'(data_len(fmt));
      pbit = (^(hold_d & data_mask(fmt))) ^ fmt.par_odd;
      if (fmt.par_en) begin
         ld_frame[pos] = pbit;
         pos = pos + 1;
      end
      ld_nbits = NBITS_W'(pos + (fmt.two_stop ? 2 : 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_d    <= '0;
         busy      <= 1'b0;
         frame_q   <= '1;
         bits_left <= '0;
         ovs_q     <= '0;
         txd_q     <= 1'b1;
      end else begin
         txd_q <= break_ctl ? 1'b0 : (busy ? frame_q[0] : 1'b1);
         if (tx_valid && !hold_v) begin
            hold_v <= 1'b1;
            hold_d <= tx_data;
         end
         if (!busy) begin
            if (hold_v) begin
               frame_q   <= ld_frame;
               bits_left <= ld_nbits;
               ovs_q     <= '0;
               busy      <= 1'b1;
               hold_v    <= 1'b0;
            end
         end else if (tick) begin
            if (ovs_q == OVS_LAST) begin
               ovs_q     <= '0;
               frame_q   <= {1'b1, frame_q[FRAME_MAX-1:1]};
               bits_left <= bits_left - 1'b1;
               if (bits_left == NBITS_W'(1)) busy <= 1'b0;
            end else begin
               ovs_q <= ovs_q + 1'b1;
            end
         end
      end
   end

   assign tx_ready = !hold_v;
   assign tx_empty = !hold_v && !busy;
   assign txd      = txd_q;

endmodule

// File: rtl/uafe_rx.sv
module uafe_rx
   import uafe_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  fmt_t              fmt,
   input  logic              rxd,
   output logic [WORD_W-1:0] rx_word,
   input  logic              rx_ready
);

   localparam int OVS_W = $clog2(OVS);
   localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
   localparam logic [OVS_W-1:0] OVS_MID  = OVS_W'(OVS / 2 - 1);

   typedef enum logic [2:0] {
      S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
   } rx_state_t;

   logic line;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
         end
         assign line = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_t         st;
   logic [OVS_W-1:0]  ovs_q;
   logic [2:0]        bit_idx;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;
   logic              all_low;
   fmt_t              fmt_q;
   logic              line_prev;
   logic [WORD_W-2:0] out_word;
   logic              out_vld;
   logic              ovr_pend;

   logic              can_load;
   logic              mid_bit;
   logic [DATA_W-1:0] got_data;
   logic              got_brk;
   logic              got_pe;

   assign can_load = !out_vld || rx_ready;
   assign mid_bit  = tick && (ovs_q == OVS_LAST);
   assign got_data = fmt_q.len7 ? {1'b0, shreg[DATA_W-1:1]} : shreg;
   assign got_brk  = all_low && !line;
   assign got_pe   = fmt_q.par_en && (par_acc ^ fmt_q.par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_HUNT;
         ovs_q     <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         all_low   <= 1'b0;
         fmt_q     <= '0;
         line_prev <= 1'b1;
         out_word  <= '0;
         out_vld   <= 1'b0;
         ovr_pend  <= 1'b0;
      end else begin
         line_prev <= line;
         if (out_vld && rx_ready) out_vld <= 1'b0;
         case (st)
            S_HUNT: begin
               if (line_prev && !line) begin
                  st    <= S_START;
                  ovs_q <= '0;
                  fmt_q <= fmt;
               end
            end
            S_START: begin
               if (tick) begin
                  if (ovs_q == OVS_MID) begin
                     ovs_q   <= '0;
                     bit_idx <= '0;
                     all_low <= 1'b1;
                     par_acc <= 1'b0;
                     st      <= line ? S_HUNT : S_DATA;
                  end else begin
                     ovs_q <= ovs_q + 1'b1;
                  end
               end
            end
            S_DATA: begin
               if (mid_bit) begin
                  ovs_q   <= '0;
                  shreg   <= {line, shreg[DATA_W-1:1]};
                  par_acc <= par_acc ^ line;
                  all_low <= all_low & !line;
                  if ({1'b0, bit_idx} == data_len(fmt_q) - 1'b1)
                     st <= fmt_q.par_en ? S_PAR : S_STOP;
                  else
                     bit_idx <= bit_idx + 1'b1;
               end else if (tick) begin
                  ovs_q <= ovs_q + 1'b1;
               end
            end
            S_PAR: begin
               if (mid_bit) begin
                  ovs_q   <= '0;
                  par_acc <= par_acc ^ line;
                  all_low <= all_low & !line;
                  st      <= S_STOP;
               end else if (tick) begin
                  ovs_q <= ovs_q + 1'b1;
               end
            end
            S_STOP: begin
               if (mid_bit) begin
                  ovs_q <= '0;
                  if (can_load) begin
                     out_word <= {got_brk, !line, ovr_pend, got_pe, got_data};
                     out_vld  <= 1'b1;
                     ovr_pend <= 1'b0;
                  end else begin
                     ovr_pend <= 1'b1;
                  end
                  st <= got_brk ? S_WAITHI : S_HUNT;
               end else if (tick) begin
                  ovs_q <= ovs_q + 1'b1;
               end
            end
            S_WAITHI: begin
               if (line) st <= S_HUNT;
            end
            default: st <= S_HUNT;
         endcase
      end
   end

   assign rx_word = {out_vld, out_word};

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
   import uafe_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [4:0]        mode,
   input  logic [7:0]        tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              break_ctl,
   output logic              txd,
   output logic              tx_empty,
   input  logic              rxd,
   output logic [12:0]       rx_word,
   input  logic              rx_ready
);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or 2 to 4");
      end
   endgenerate

   logic tick;
   fmt_t fmt;

   assign fmt = fmt_decode(mode);

   uafe_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (tick)
   );

   uafe_tx #(.OVS(OVS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .fmt       (fmt),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .break_ctl (break_ctl),
      .txd       (txd),
      .tx_empty  (tx_empty)
   );

   uafe_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .fmt      (fmt),
      .rxd      (rxd),
      .rx_word  (rx_word),
      .rx_ready (rx_ready)
   );

endmodule

// File: rtl/uafe_checker.sv
module uafe_checker #(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [DIV_W-1:0] divisor,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             tx_empty,
   input logic             break_ctl,
   input logic             txd,
   input logic [12:0]      rx_word,
   input logic             rx_ready
);

   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor != '0) |=> !tick);

   a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      break_ctl |=> !txd);

   a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && $past(tx_empty) && !$past(break_ctl)) |-> txd);

   a_r11_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (!tx_ready && !tx_empty));

   a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_word[12] && !rx_ready) |=> (rx_word[12] && $stable(rx_word)));

   a_r9_break_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_word[12] && rx_word[11]) |-> (rx_word[10] && rx_word[7:0] == 8'h00));

endmodule

bind uart_frame_engine uafe_checker #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .divisor   (divisor),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_empty  (tx_empty),
   .break_ctl (break_ctl),
   .txd       (txd),
   .rx_word   (rx_word),
   .rx_ready  (rx_ready)
);

// File: tb/tb_uart_frame_engine.sv
`timescale 1ns/1ps
module tb_uart_frame_engine;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 3;
   localparam int OVS        = 16;
   localparam int TICK_CLK   = DIV + 1;
   localparam int BIT        = OVS * TICK_CLK;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] divisor = 16'(DIV);
   logic [4:0]  mode = 5'h00;
   logic [7:0]  tx_data = 8'h00;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic        break_ctl = 1'b0;
   logic        txd;
   logic        tx_empty;
   logic        rxd;
   logic [12:0] rx_word;
   logic        rx_ready = 1'b1;
   logic        loop_sel = 1'b1;
   logic        bb_line = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;

   logic [12:0] expq[$];
   string       tagq[$];

   assign rxd = loop_sel ? txd : bb_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_frame_engine #(.DIV_W(16), .OVS(OVS), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .mode(mode),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .break_ctl(break_ctl), .txd(txd), .tx_empty(tx_empty),
      .rxd(rxd), .rx_word(rx_word), .rx_ready(rx_ready)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [12:0] exp_word(input logic [7:0] d, input logic [4:0] m,
                                             input logic ovr);
      logic [7:0] dd;
      dd = m[0] ? (d & 8'h7f) : d;
      return {1'b1, 1'b0, 1'b0, ovr, 1'b0, dd};
   endfunction

   // Monitor: compares every accepted word with the scoreboard head.
   always @(negedge clk) begin
      if (rst_n && rx_word[12] && rx_ready) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R7 unexpected word", int'(rx_word), 0);
         end else begin
            logic [12:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(rx_word == e, t, int'(rx_word), int'(e));
         end
      end
   end

   task automatic push_exp(input logic [12:0] w, input string t);
      expq.push_back(w);
      tagq.push_back(t);
   endtask

   task automatic send_byte(input logic [7:0] d, input bit push, input logic ovr,
                            input string t);
      if (push) push_exp(exp_word(d, mode, ovr), t);
      @(posedge clk); #1;
      tx_data  = d;
      tx_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (tx_ready) begin
            @(posedge clk); #1;
            tx_valid = 1'b0;
            break;
         end
      end
   endtask

   task automatic wait_idle();
      while (!tx_empty) @(negedge clk);
      repeat (3 * BIT) @(negedge clk);
   endtask

   task automatic capture(output logic [11:0] bits);
      while (txd) @(negedge clk);
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         bits[i] = txd;
         if (i < 11) repeat (BIT) @(negedge clk);
      end
   endtask

   task automatic bang(input logic [15:0] v, input int n);
      @(posedge clk); #1;
      for (int i = 0; i < n; i++) begin
         bb_line = v[i];
         repeat (BIT) @(posedge clk);
         #1;
      end
      bb_line = 1'b1;
      repeat (3 * BIT) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [11:0] fr;
      int lowlen;

      repeat (5) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R11 reset txd high", int'(txd), 1);
      chk(tx_empty == 1'b1, "R11 reset tx_empty", int'(tx_empty), 1);
      chk(tx_ready == 1'b1, "R11 reset tx_ready", int'(tx_ready), 1);
      chk(rx_word[12] == 1'b0, "R5 reset word invalid", int'(rx_word[12]), 0);

      // R1: start bit width, byte 0xFF so only the start bit is low
      mode = 5'h00;
      fork
         send_byte(8'hFF, 1, 1'b0, "R1 loop 0xFF");
         begin
            while (txd) @(negedge clk);
            lowlen = 0;
            while (!txd) begin lowlen++; @(negedge clk); end
         end
      join
      chk(lowlen >= (OVS-1)*TICK_CLK+1 && lowlen <= OVS*TICK_CLK,
          "R1 start bit length", lowlen, BIT);
      wait_idle();

      // R5: several 8N1 patterns through loopback
      send_byte(8'hA5, 1, 1'b0, "R5 loop 0xA5");
      send_byte(8'h3C, 1, 1'b0, "R5 loop 0x3C");
      send_byte(8'h01, 1, 1'b0, "R5 loop 0x01");
      send_byte(8'h80, 1, 1'b0, "R5 loop 0x80");
      wait_idle();

      // R2: 7-bit line image and masking
      mode = 5'h01;
      fork
         send_byte(8'h55, 1, 1'b0, "R2 loop 7-bit 0x55");
         capture(fr);
      join
      chk(fr[8] == 1'b1 && fr[7:1] == 7'h55, "R2 7-bit stop position",
          int'(fr[8:0]), 9'h1AA);
      wait_idle();
      send_byte(8'hD5, 1, 1'b0, "R2 loop 7-bit 0xD5 masked");
      wait_idle();

      // R3: stop count with back-to-back characters
      mode = 5'h04;
      fork
         begin
            send_byte(8'h00, 1, 1'b0, "R3 loop 8N2 a");
            send_byte(8'h00, 1, 1'b0, "R3 loop 8N2 b");
            chk(tx_ready == 1'b0 && tx_empty == 1'b0, "R11 holding full while busy",
                int'({tx_ready, tx_empty}), 0);
         end
         capture(fr);
      join
      chk(fr[10:9] == 2'b11 && fr[11] == 1'b0, "R3 two stop bits",
          int'(fr[11:9]), 3'b011);
      wait_idle();
      chk(tx_empty == 1'b1, "R11 empty after frames", int'(tx_empty), 1);
      mode = 5'h00;
      fork
         begin
            send_byte(8'h00, 1, 1'b0, "R3 loop 8N1 a");
            send_byte(8'h00, 1, 1'b0, "R3 loop 8N1 b");
         end
         capture(fr);
      join
      chk(fr[9] == 1'b1 && fr[10] == 1'b0, "R3 one stop bit",
          int'(fr[10:9]), 2'b01);
      wait_idle();

      // R4: parity bit sense on the line
      mode = 5'h10;
      fork
         send_byte(8'h07, 1, 1'b0, "R4 loop even");
         capture(fr);
      join
      chk(fr[9] == 1'b1 && fr[10] == 1'b1, "R4 even parity bit", int'(fr[10:9]), 3);
      wait_idle();
      mode = 5'h18;
      fork
         send_byte(8'h07, 1, 1'b0, "R4 loop odd");
         capture(fr);
      join
      chk(fr[9] == 1'b0 && fr[10] == 1'b1, "R4 odd parity bit", int'(fr[10:9]), 2);
      wait_idle();

      // R6 and R9: break
      mode = 5'h00;
      push_exp(13'b1_1100_0000_0000, "R9 break word");
      @(posedge clk); #1;
      break_ctl = 1'b1;
      repeat (2) @(negedge clk);
      chk(txd == 1'b0, "R6 break drives low", int'(txd), 0);
      repeat (14 * BIT) @(negedge clk);
      chk(txd == 1'b0, "R6 break still low", int'(txd), 0);
      @(posedge clk); #1;
      break_ctl = 1'b0;
      repeat (3 * BIT) @(negedge clk);
      send_byte(8'h5A, 1, 1'b0, "R9 recovery after break");
      wait_idle();

      // R8: framing error
      loop_sel = 1'b0;
      push_exp(13'b1_0100_0101_0101, "R8 framing error");
      bang({6'h3f, 1'b0, 8'h55, 1'b0}, 10);

      // R12: parity error and correct parity
      mode = 5'h10;
      push_exp(13'b1_0001_0000_0111, "R12 parity error");
      bang({5'h1f, 1'b1, 1'b0, 8'h07, 1'b0}, 11);
      push_exp(13'b1_0000_0000_0111, "R12 parity correct");
      bang({5'h1f, 1'b1, 1'b1, 8'h07, 1'b0}, 11);

      // R7: glitch rejection
      mode = 5'h00;
      @(posedge clk); #1;
      bb_line = 1'b0;
      repeat (4 * TICK_CLK) @(posedge clk);
      #1;
      bb_line = 1'b1;
      repeat (2 * BIT) @(posedge clk);
      push_exp(exp_word(8'h33, mode, 1'b0), "R7 byte after glitch");
      bang({6'h3f, 1'b1, 8'h33, 1'b0}, 10);
      loop_sel = 1'b1;
      repeat (BIT) @(negedge clk);

      // R10: overrun
      @(posedge clk); #1;
      rx_ready = 1'b0;
      send_byte(8'hC3, 1, 1'b0, "R10 held word no overrun");
      wait_idle();
      send_byte(8'h99, 0, 1'b0, "R10 dropped");
      wait_idle();
      chk(rx_word[12] == 1'b1 && rx_word[7:0] == 8'hC3, "R10 first word kept",
          int'(rx_word), 13'h10C3);
      @(posedge clk); #1;
      rx_ready = 1'b1;
      repeat (4) @(negedge clk);
      send_byte(8'h24, 1, 1'b1, "R10 overrun flagged");
      wait_idle();

      chk(expq.size() == 0, "R5 all expected words seen", expq.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule